// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Frame Reader

This block is the host side of a three-wire link to a 24-bit delta-sigma converter that runs from an externally supplied serial clock. On a start request it pulls chip select low while keeping the serial clock low, so the converter picks external clock mode. It then reads the conversion-status level on the data line. If the converter is still busy, the reader releases chip select without clocking, waits a programmable back-off, and polls again.

Once the converter reports ready, the reader issues exactly 32 clock pulses. It captures one bit on each pulse, most significant first. It then releases chip select and splits the captured word into its parts. The four status bits lead the word, in this order: end-of-conversion, a dummy bit, the sign, and the out-of-range bit. Next come 24 result bits from MSB to LSB, and four extra low-order bits come last and are dropped. The 24-bit result, the sign and two fault flags are presented with a one-cycle valid strobe.

The serial clock half-period and the retry interval are both given in system clocks on input buses. The incoming data line passes through a two-flop synchroniser before use.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, result_valid is 0, and result, sign_pos, dmy_fault and range_fault are all 0.
- R2: A start request in idle drives cs_n low while sck is 0. A start request held or repeated while a read is in progress does not open another chip-select window.
- R3: When the data line is 1 at the poll point, cs_n returns to 1 without any sck pulse. It stays 1 for retry_gap+1 system clocks and then falls again to re-poll.
- R4: During a frame, every sck high phase lasts half_period system clocks, and every low phase between two pulses also lasts half_period system clocks.
- R5: A frame has exactly 32 rising sck edges in one chip-select window. cs_n rises only after the 32nd falling edge, with sck low.
- R6: With the frame bits numbered 31 (first received) down to 0, result equals bits 27..4. Bits 3..0 are discarded.
- R7: sign_pos equals frame bit 29.
- R8: dmy_fault equals frame bit 30, because that bit must be 0 in a healthy frame.
- R9: range_fault equals frame bit 28, which is set when the input lies outside 0..reference.
- R10: result_valid is high for exactly one cycle per frame, in the first cycle with cs_n back at 1. result and the flags hold their values between strobes.
- R11: A half_period value below 2 behaves as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion read |
| half_period | input | CNT_W | SCK high and low time in system clocks (minimum 2) |
| retry_gap | input | CNT_W | Back-off between busy polls, in system clocks |
| sdo | input | 1 | Serial data from converter (asynchronous) |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock to converter |
| result | output | 24 | Conversion result |
| sign_pos | output | 1 | Sign bit from the frame |
| dmy_fault | output | 1 | Dummy bit was set |
| range_fault | output | 1 | Input out of range |
| result_valid | output | 1 | One-cycle strobe for result and flags |

## Verification
The bench builds the reader with CNT_W = 4, so the all-ones settings are reachable in a short run. Those are a 15-clock half-period and a 15-clock back-off. Other cases use half-periods of 0, 2 and 3, which exercise both the minimum clamp and the tightest legal timing against the two-flop synchroniser's latency. A behavioural converter model answers busy for a chosen number of polls and shifts its frame on falling sck edges. This lets repeated back-offs, each status-bit combination, and a start held through a whole read all be checked at the pins.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    localparam int FRAME_W    = 32;
    localparam int DATA_W     = 24;
    localparam int SUB_W      = 4;
    localparam int SETTLE_CYC = 3;   // clocks from CS fall to busy poll
    localparam int MIN_HALF   = 2;
    localparam int BIT_W      = $clog2(FRAME_W);

    typedef struct packed {
        logic              eoc;
        logic              dmy;
        logic              sig;
        logic              exr;
        logic [DATA_W-1:0] data;
        logic [SUB_W-1:0]  sub;
    } frame_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sig;
        logic              dmy_fault;
        logic              range_fault;
    } result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_BACKOFF,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } state_t;

    function automatic result_t decode(input frame_t f);
        result_t r;
        r.data        = f.data;
        r.sig         = f.sig;
        r.dmy_fault   = f.dmy;
        r.range_fault = f.exr;
        return r;
    endfunction
endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  half_period,
    input  logic [CNT_W-1:0]  retry_gap,
    input  logic              sdo,
    output logic              cs_n,
    output logic              sck,
    output logic [DATA_W-1:0] result,
    output logic              sign_pos,
    output logic              dmy_fault,
    output logic              range_fault,
    output logic              result_valid
);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] HALF_MIN  = CNT_W'(MIN_HALF);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

    state_t             state, state_n;
    logic               cs_nx, sck_nx;
    logic               tmr_ld, tmr_done, shift_en, finish;
    logic [CNT_W-1:0]   tmr_val, half_eff;
    logic               sdo_s;
    logic [FRAME_W-1:0] frame_q;
    logic [BIT_W-1:0]   bit_cnt;
    result_t            dec;

    adcrd_sync #(.STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d (sdo), .q (sdo_s)
    );

    adcrd_timer #(.W(CNT_W)) u_timer (
        .clk (clk), .rst (rst), .load (tmr_ld), .val (tmr_val), .done (tmr_done)
    );

    adcrd_shift #(.W(FRAME_W)) u_shift (
        .clk (clk), .rst (rst), .en (shift_en), .din (sdo_s), .q (frame_q)
    );

    assign half_eff = (half_period < HALF_MIN) ? HALF_MIN : half_period;
    assign dec      = decode(frame_t'(frame_q));

    always_comb begin
        state_n  = state;
        cs_nx    = cs_n;
        sck_nx   = sck;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        shift_en = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    cs_nx   = 1'b0;
                    tmr_ld  = 1'b1;
                    tmr_val = SETTLE_LD;
                    state_n = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    tmr_ld = 1'b1;
                    if (sdo_s) begin
                        cs_nx   = 1'b1;
                        tmr_val = retry_gap;
                        state_n = ST_BACKOFF;
                    end else begin
                        tmr_val = half_eff - 1'b1;
                        state_n = ST_LOW;
                    end
                end
            end
            ST_BACKOFF: begin
                if (tmr_done) begin
                    cs_nx   = 1'b0;
                    tmr_ld  = 1'b1;
                    tmr_val = SETTLE_LD;
                    state_n = ST_SETTLE;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    sck_nx  = 1'b1;
                    tmr_ld  = 1'b1;
                    tmr_val = half_eff - 1'b1;
                    state_n = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    sck_nx   = 1'b0;
                    shift_en = 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        state_n = ST_DONE;
                    end else begin
                        tmr_ld  = 1'b1;
                        tmr_val = half_eff - 1'b1;
                        state_n = ST_LOW;
                    end
                end
            end
            ST_DONE: begin
                cs_nx   = 1'b1;
                finish  = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            bit_cnt <= '0;
        end else begin
            state <= state_n;
            cs_n  <= cs_nx;
            sck   <= sck_nx;
            if (state == ST_IDLE) bit_cnt <= '0;
            else if (shift_en)    bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            sign_pos     <= 1'b0;
            dmy_fault    <= 1'b0;
            range_fault  <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= finish;
            if (finish) begin
                result      <= dec.data;
                sign_pos    <= dec.sig;
                dmy_fault   <= dec.dmy_fault;
                range_fault <= dec.range_fault;
            end
        end
    end
endmodule

// File: rtl/adcrd_chk.sv
module adcrd_chk
    import adcrd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sck,
    input logic              result_valid,
    input logic [DATA_W-1:0] result
);
    logic       cs_q, sck_q;
    logic [6:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            rises <= '0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            if (cs_q && !cs_n)       rises <= '0;
            else if (!sck_q && sck)  rises <= rises + 1'b1;
        end
    end

    // R2
    cs_fall_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sck);

    // R5
    sck_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> !cs_n);

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rises == 7'd0 || rises == 7'd32));

    // R5
    cs_rise_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !sck);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R10
    valid_cs_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> cs_n);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));
endmodule

bind adc_frame_reader adcrd_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .sck          (sck),
    .result_valid (result_valid),
    .result       (result)
);

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] half_period = 4'd2;
    logic [CNT_W-1:0] retry_gap = 4'd0;
    logic             sdo;
    logic             cs_n, sck;
    logic [23:0]      result;
    logic             sign_pos, dmy_fault, range_fault, result_valid;

    always #2 clk = ~clk;

    adc_frame_reader #(.CNT_W(CNT_W)) u0 (
        .clk (clk), .rst (rst), .start (start),
        .half_period (half_period), .retry_gap (retry_gap), .sdo (sdo),
        .cs_n (cs_n), .sck (sck), .result (result), .sign_pos (sign_pos),
        .dmy_fault (dmy_fault), .range_fault (range_fault),
        .result_valid (result_valid)
    );

    // converter model
    logic [31:0] adc_frame = '0;
    int          busy_left = 0;
    logic        adc_busy = 1'b0;
    int          bit_idx = 31;

    always @(negedge cs_n) begin
        if (busy_left > 0) begin
            adc_busy  = 1'b1;
            busy_left = busy_left - 1;
        end else begin
            adc_busy = 1'b0;
        end
        bit_idx = 31;
    end

    always @(negedge sck) begin
        if (!cs_n && !adc_busy && bit_idx > 0) bit_idx = bit_idx - 1;
    end

    assign sdo = cs_n ? 1'b1 : (adc_busy ? 1'b1 : adc_frame[bit_idx]);

    // pin monitor
    int   pulses, hi_len, lo_len, hi_bad, lo_bad, gap_len, last_gap;
    int   retries, vcount, valid_cs_bad, cs_fall_bad, cs_falls, exp_half;
    logic txn = 1'b0, prev_sck = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (sck) hi_len = hi_len + 1;
            if (prev_sck && !sck) begin
                if (hi_len != exp_half) hi_bad = hi_bad + 1;
                hi_len = 0;
            end
            if (!prev_sck && sck) begin
                if (pulses > 0 && lo_len != exp_half) lo_bad = lo_bad + 1;
                lo_len = 0;
                pulses = pulses + 1;
            end else if (!sck && !cs_n && pulses > 0) begin
                lo_len = lo_len + 1;
            end
            if (prev_cs && !cs_n) begin
                if (sck) cs_fall_bad = cs_fall_bad + 1;
                if (txn && gap_len > 0) begin
                    retries  = retries + 1;
                    last_gap = gap_len;
                end
                txn      = 1'b1;
                gap_len  = 0;
                cs_falls = cs_falls + 1;
            end
            if (cs_n && txn && pulses == 0) gap_len = gap_len + 1;
            if (result_valid) begin
                vcount = vcount + 1;
                if (!cs_n) valid_cs_bad = valid_cs_bad + 1;
                txn = 1'b0;
            end
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        pulses = 0; hi_len = 0; lo_len = 0; hi_bad = 0; lo_bad = 0;
        gap_len = 0; last_gap = 0; retries = 0; vcount = 0;
        valid_cs_bad = 0; cs_fall_bad = 0; cs_falls = 0; txn = 1'b0;
        prev_sck = sck; prev_cs = cs_n;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck", sck, 0);
        chk("R1 valid", result_valid, 0);
        chk("R1 result", result, 0);
        chk("R1 flags", {sign_pos, dmy_fault, range_fault}, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one read: frame bits, busy polls, half period, retry gap, held start
    task automatic run_frame(input logic [31:0] fr, input int busy,
                             input logic [CNT_W-1:0] half, input logic [CNT_W-1:0] gap,
                             input bit hold_start, input string treq);
        logic [23:0] cap;
        bit          got;
        int          eh;
        eh = (half < 2) ? 2 : int'(half);
        @(negedge clk); #1;
        adc_frame = fr; busy_left = busy; half_period = half; retry_gap = gap;
        exp_half = eh;
        mon_clear();
        start = 1'b1;
        @(negedge clk); #1;
        if (!hold_start) start = 1'b0;
        got = 1'b0;
        cap = '0;
        for (int i = 0; i < 8000 && !got; i++) begin
            @(negedge clk); #1;
            if (result_valid) begin
                got   = 1'b1;
                start = 1'b0;
                cap   = result;
                chk("R6 result", result, fr[27:4]);
                chk("R7 sign", sign_pos, fr[29]);
                chk("R8 dummy fault", dmy_fault, fr[30]);
                chk("R9 range fault", range_fault, fr[28]);
            end
        end
        start = 1'b0;
        chk("R10 strobe seen", got, 1);
        repeat (6) @(negedge clk);
        #1;
        chk("R10 single strobe", vcount, 1);
        chk("R10 strobe with cs high", valid_cs_bad, 0);
        chk("R10 result held", result, cap);
        chk("R5 pulse count", pulses, 32);
        chk({treq, " high time"}, hi_bad, 0);
        chk({treq, " low time"}, lo_bad, 0);
        chk("R2 cs fell with sck low", cs_fall_bad, 0);
        chk("R2 windows per read", cs_falls, busy + 1);
        chk("R3 busy retries", retries, busy);
        if (busy > 0) chk("R3 back-off length", last_gap, int'(gap) + 1);
    endtask

    task automatic test_plain();
        run_frame({1'b0, 1'b0, 1'b1, 1'b0, 24'hA5C3F1, 4'hF}, 0, 4'd2, 4'd0, 1'b0, "R4");
    endtask

    task automatic test_busy_dummy();
        run_frame({1'b0, 1'b1, 1'b0, 1'b0, 24'h000001, 4'h9}, 2, 4'd3, 4'd5, 1'b0, "R4");
    endtask

    task automatic test_max_settings_held_start();
        run_frame({1'b0, 1'b0, 1'b1, 1'b1, 24'hFFFFFF, 4'h0}, 1, 4'd15, 4'd15, 1'b1, "R4");
    endtask

    task automatic test_half_clamp();
        run_frame({1'b0, 1'b0, 1'b0, 1'b0, 24'h800000, 4'h0}, 0, 4'd0, 4'd0, 1'b0, "R11");
        run_frame({1'b0, 1'b1, 1'b1, 1'b1, 24'h000000, 4'hF}, 1, 4'd1, 4'd0, 1'b0, "R11");
    endtask

    initial begin
        #(4ns * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        test_reset();
        test_plain();
        test_busy_dummy();
        test_max_settings_held_start();
        test_half_clamp();
        summary();
    end
endmodule